// File: doc/BRIEF.md
# Configuration Access Guard

This block sits in front of the two configuration memories of a programmable device: a volatile configuration SRAM and a non-volatile configuration store. A requester presents one command at a time (read back, erase, program or set-secure) together with a target select. The guard checks each command against the protection state it keeps and answers with a one-cycle grant or deny pulse and a reason code. The protection state is one security bit per target plus a one-time lock fuse. Granted memory operations go out on a simple request/acknowledge port. The array behind that port is not part of this block.

Each security bit protects only its own target. The non-volatile security bit survives reset and is cleared only when its own memory is erased. A reset clears the SRAM security bit. The one-time lock fuse is sticky: once blown, it blocks every SRAM erase and program for good.

The control state machine has two states. In `ST_IDLE` it accepts a command; a granted memory command moves it to `ST_MEM` (transition *issue*). In `ST_MEM` it holds the memory request and reports busy until acknowledge (transition *complete*, back to `ST_IDLE`). Denied and set-secure commands leave it in `ST_IDLE` (transition *stay*). Reset forces `ST_IDLE`.

Top module: `cfg_access_guard`

## Requirements
- R1: A read back (op 00) of a target whose security bit is set is denied with reason 01 and raises no memory request.
- R2: A set security bit affects only its own target (0 = SRAM, 1 = non-volatile). A read back of the other target is still granted.
- R3: An erase (op 01) of the non-volatile target is granted and clears its security bit in the same step. Reset and other commands leave that bit set.
- R4: A program (op 10) of a secured target is denied with reason 01. After that target is erased, a program of it is granted.
- R5: While the lock fuse is blown, every SRAM erase and program is denied with reason 10. This reason takes precedence over reason 01. The non-volatile target is not affected.
- R6: The lock is set only by the fuse input, and neither reset nor any command clears it.
- R7: Set-secure (op 11) is always granted, even under lock. It sets the target's security bit and raises no memory request.
- R8: Each accepted command gets exactly one grant or deny pulse, in the cycle after the edge that accepts it. The reason is 00 on a grant.
- R9: Busy is high from the cycle after a granted memory command until the acknowledge edge. Commands presented while busy get no response and are taken once the block is idle again.
- R10: Reset clears the SRAM security bit and leaves grant, deny, busy and the memory request low.
- R11: The memory request carries the granted op and target and holds them steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fuse_blow_i | input | 1 | One-time lock fuse state; high blows the lock |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 00 read back, 01 erase, 10 program, 11 set-secure |
| cmd_tgt_i | input | 1 | 0 SRAM, 1 non-volatile |
| grant_o | output | 1 | One-cycle grant pulse |
| deny_o | output | 1 | One-cycle deny pulse |
| reason_o | output | 2 | 00 ok, 01 secured, 10 locked; valid with a pulse |
| busy_o | output | 1 | Memory operation outstanding |
| mem_req_o | output | 1 | Memory operation request |
| mem_op_o | output | 2 | Op of the request |
| mem_tgt_o | output | 1 | Target of the request |
| mem_ack_i | input | 1 | Memory operation finished |

## Verification
The bench drives a secured SRAM under lock and expects reason 10. A design that tests the security bit before the lock would answer 01 there. It resets while the non-volatile bit is set and expects the read back to stay denied, which catches a design that resets the wrong bit or both bits. It holds a command through a busy window and expects no response until one cycle after the block goes idle. A design that drops or answers held commands early would fail that check. It also resets after the fuse is blown and expects the lock to survive.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_ERASE  = 2'b01,
        OP_PROG   = 2'b10,
        OP_SECURE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        RSN_OK      = 2'b00,
        RSN_SECURED = 2'b01,
        RSN_LOCKED  = 2'b10
    } reason_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } state_e;

endpackage

// File: rtl/cgd_fuse_bank.sv
module cgd_fuse_bank #(
    parameter int          N_TGT         = 2,
    parameter logic [31:0] VOLATILE_MASK = 32'h1,
    localparam int         TGT_W         = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [TGT_W-1:0] tgt,
    input  logic             fuse_blow,
    output logic [N_TGT-1:0] sec_vec,
    output logic             lock
);

    // Sticky lock: no reset term, only the fuse input sets it.
    logic lock_q = 1'b0;

    always_ff @(posedge clk) begin
        lock_q <= lock_q | fuse_blow;
    end

    assign lock = lock_q;

    a_r6_lock_sticky: assert property (@(posedge clk) lock_q |=> lock_q);

    for (genvar i = 0; i < N_TGT; i++) begin : g_sec
        logic hit;
        assign hit = (tgt == i[TGT_W-1:0]);

        if (VOLATILE_MASK[i]) begin : g_vol
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)               bit_q <= 1'b0;
                else if (set_en && hit)   bit_q <= 1'b1;
                else if (clr_en && hit)   bit_q <= 1'b0;
            end
            assign sec_vec[i] = bit_q;
        end else begin : g_nv
            logic bit_q = 1'b0;
            always_ff @(posedge clk) begin
                if (set_en && hit)        bit_q <= 1'b1;
                else if (clr_en && hit)   bit_q <= 1'b0;
            end
            assign sec_vec[i] = bit_q;

            // R3: the retained bit falls only through an erase of its own target
            a_r3_clear_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(bit_q) |-> $past(clr_en && hit));
        end
    end

endmodule

// File: rtl/cgd_policy.sv
module cgd_policy
    import cfg_guard_pkg::*;
#(
    parameter int N_TGT    = 2,
    parameter int LOCK_TGT = 0,
    localparam int TGT_W   = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  op_e              op,
    input  logic [TGT_W-1:0] tgt,
    input  logic [N_TGT-1:0] sec_vec,
    input  logic             lock,
    output logic             allow,
    output reason_e          reason,
    output logic             needs_mem,
    output logic             set_sec,
    output logic             clr_sec
);

    logic tgt_locked;
    logic tgt_secured;

    assign tgt_locked  = lock && (tgt == LOCK_TGT[TGT_W-1:0]);
    assign tgt_secured = sec_vec[tgt];

    always_comb begin
        allow     = 1'b1;
        reason    = RSN_OK;
        needs_mem = 1'b0;
        set_sec   = 1'b0;
        clr_sec   = 1'b0;
        unique case (op)
            OP_READ: begin
                if (tgt_secured) begin
                    allow  = 1'b0;
                    reason = RSN_SECURED;
                end else begin
                    needs_mem = 1'b1;
                end
            end
            OP_ERASE: begin
                if (tgt_locked) begin
                    allow  = 1'b0;
                    reason = RSN_LOCKED;
                end else begin
                    needs_mem = 1'b1;
                    clr_sec   = 1'b1;
                end
            end
            OP_PROG: begin
                if (tgt_locked) begin
                    allow  = 1'b0;
                    reason = RSN_LOCKED;
                end else if (tgt_secured) begin
                    allow  = 1'b0;
                    reason = RSN_SECURED;
                end else begin
                    needs_mem = 1'b1;
                end
            end
            OP_SECURE: begin
                set_sec = 1'b1;
            end
            default: begin
                allow = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfg_access_guard.sv
module cfg_access_guard
    import cfg_guard_pkg::*;
#(
    parameter int          N_TGT         = 2,
    parameter int          LOCK_TGT      = 0,
    parameter logic [31:0] VOLATILE_MASK = 32'h1,
    localparam int         TGT_W         = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_blow_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [TGT_W-1:0] cmd_tgt_i,
    output logic             grant_o,
    output logic             deny_o,
    output logic [1:0]       reason_o,
    output logic             busy_o,
    output logic             mem_req_o,
    output logic [1:0]       mem_op_o,
    output logic [TGT_W-1:0] mem_tgt_o,
    input  logic             mem_ack_i
);

    state_e           state_q, state_d;
    logic             accept;
    op_e              op_in;
    logic [N_TGT-1:0] sec_vec;
    logic             lock;
    logic             allow, needs_mem, set_sec, clr_sec;
    reason_e          reason;
    logic             grant_q, deny_q;
    reason_e          reason_q;
    logic [1:0]       mop_q;
    logic [TGT_W-1:0] mtgt_q;

    assign op_in  = op_e'(cmd_op_i);
    assign accept = cmd_valid_i && (state_q == ST_IDLE);

    cgd_policy #(.N_TGT(N_TGT), .LOCK_TGT(LOCK_TGT)) u_policy (
        .op        (op_in),
        .tgt       (cmd_tgt_i),
        .sec_vec   (sec_vec),
        .lock      (lock),
        .allow     (allow),
        .reason    (reason),
        .needs_mem (needs_mem),
        .set_sec   (set_sec),
        .clr_sec   (clr_sec)
    );

    cgd_fuse_bank #(.N_TGT(N_TGT), .VOLATILE_MASK(VOLATILE_MASK)) u_fuses (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (accept && allow && set_sec),
        .clr_en    (accept && allow && clr_sec),
        .tgt       (cmd_tgt_i),
        .fuse_blow (fuse_blow_i),
        .sec_vec   (sec_vec),
        .lock      (lock)
    );

    // Next-state logic: issue / complete / stay
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && allow && needs_mem) state_d = ST_MEM;
            ST_MEM:  if (mem_ack_i)                    state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            deny_q   <= 1'b0;
            reason_q <= RSN_OK;
            mop_q    <= '0;
            mtgt_q   <= '0;
        end else begin
            grant_q  <= accept && allow;
            deny_q   <= accept && !allow;
            reason_q <= accept ? reason : RSN_OK;
            if (accept && allow && needs_mem) begin
                mop_q  <= cmd_op_i;
                mtgt_q <= cmd_tgt_i;
            end
        end
    end

    assign grant_o   = grant_q;
    assign deny_o    = deny_q;
    assign reason_o  = reason_q;
    assign busy_o    = (state_q == ST_MEM);
    assign mem_req_o = (state_q == ST_MEM);
    assign mem_op_o  = mop_q;
    assign mem_tgt_o = mtgt_q;

    a_r1_secured_read_denied: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_in == OP_READ && sec_vec[cmd_tgt_i]
        |=> deny_o && reason_o == 2'b01 && !mem_req_o);

    a_r5_lock_blocks_sram: assert property (@(posedge clk) disable iff (!rst_n)
        accept && lock && cmd_tgt_i == LOCK_TGT[TGT_W-1:0]
        && (op_in == OP_ERASE || op_in == OP_PROG)
        |=> deny_o && reason_o == 2'b10);

    a_r7_secure_granted: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_in == OP_SECURE |=> grant_o && !mem_req_o);

    a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    a_r9_busy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !mem_ack_i |=> busy_o && !grant_o && !deny_o);

    a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_op_o) && $stable(mem_tgt_o));

endmodule

// File: tb/sim_cfg_access_guard.sv
module sim_cfg_access_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_blow_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [1:0] cmd_op_i = 2'b00;
    logic       cmd_tgt_i = 1'b0;
    logic       grant_o, deny_o, busy_o, mem_req_o, mem_ack_i;
    logic [1:0] reason_o, mem_op_o;
    logic       mem_tgt_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    initial mem_ack_i = 1'b0;

    cfg_access_guard u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .fuse_blow_i (fuse_blow_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_tgt_i   (cmd_tgt_i),
        .grant_o     (grant_o),
        .deny_o      (deny_o),
        .reason_o    (reason_o),
        .busy_o      (busy_o),
        .mem_req_o   (mem_req_o),
        .mem_op_o    (mem_op_o),
        .mem_tgt_o   (mem_tgt_o),
        .mem_ack_i   (mem_ack_i)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // response word: {grant, deny, reason}
    function automatic logic [7:0] resp();
        return {4'b0, grant_o, deny_o, reason_o};
    endfunction

    task automatic send(input logic [1:0] op, input logic tgt);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_tgt_i   = tgt;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic ack(input string req);
        mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0;
        chk(req, {7'b0, busy_o}, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R10 idle after reset", {4'b0, grant_o, deny_o, busy_o, mem_req_o}, 8'h00);
    endtask

    task automatic t_plain_read();
        send(2'b00, 1'b0);
        chk("R8 read granted reason 00", resp(), 8'b1000);
        chk("R11 request op/tgt", {4'b0, mem_req_o, mem_op_o, mem_tgt_o}, 8'b1000);
        chk("R9 busy after grant", {7'b0, busy_o}, 8'h01);
        @(negedge clk);
        chk("R11 request held", {4'b0, mem_req_o, mem_op_o, mem_tgt_o}, 8'b1000);
        ack("R9 busy clears on ack");
    endtask

    task automatic t_secure_isolation();
        send(2'b11, 1'b0);
        chk("R7 set-secure granted", resp(), 8'b1000);
        chk("R7 no memory request", {7'b0, mem_req_o}, 8'h00);
        send(2'b00, 1'b0);
        chk("R1 secured read denied 01", resp(), 8'b0101);
        chk("R1 no memory request", {7'b0, mem_req_o}, 8'h00);
        send(2'b00, 1'b1);
        chk("R2 other target read granted", resp(), 8'b1000);
        ack("R2 ack");
    endtask

    task automatic t_erase_then_program();
        send(2'b10, 1'b0);
        chk("R4 program secured denied 01", resp(), 8'b0101);
        send(2'b01, 1'b0);
        chk("R4 erase granted", resp(), 8'b1000);
        chk("R11 erase request", {4'b0, mem_req_o, mem_op_o, mem_tgt_o}, 8'b1010);
        ack("R4 ack erase");
        send(2'b10, 1'b0);
        chk("R4 program after erase granted", resp(), 8'b1000);
        ack("R4 ack program");
    endtask

    task automatic t_nv_retention();
        send(2'b11, 1'b1);
        send(2'b11, 1'b0);
        send(2'b00, 1'b1);
        chk("R1 nv read denied", resp(), 8'b0101);
        do_reset();
        send(2'b00, 1'b1);
        chk("R3 nv bit survives reset", resp(), 8'b0101);
        send(2'b00, 1'b0);
        chk("R10 sram bit cleared by reset", resp(), 8'b1000);
        ack("R10 ack");
        send(2'b01, 1'b1);
        chk("R3 nv erase granted", resp(), 8'b1000);
        chk("R11 nv erase request", {4'b0, mem_req_o, mem_op_o, mem_tgt_o}, 8'b1011);
        ack("R3 ack");
        send(2'b00, 1'b1);
        chk("R3 nv read after erase granted", resp(), 8'b1000);
        ack("R3 ack read");
    endtask

    task automatic t_busy_hold();
        send(2'b10, 1'b1);
        chk("R9 program nv granted", resp(), 8'b1000);
        cmd_valid_i = 1'b1;
        cmd_op_i    = 2'b00;
        cmd_tgt_i   = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 no response while busy", {5'b0, busy_o, grant_o, deny_o}, 8'b100);
            chk("R11 held request unchanged", {4'b0, mem_req_o, mem_op_o, mem_tgt_o}, 8'b1101);
        end
        mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0;
        chk("R9 idle, held cmd not yet answered", {5'b0, busy_o, grant_o, deny_o}, 8'h00);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk("R9 held cmd answered when idle", resp(), 8'b1000);
        ack("R9 ack held read");
    endtask

    task automatic t_lock();
        send(2'b01, 1'b0);
        chk("R6 sram erase granted before fuse", resp(), 8'b1000);
        ack("R6 ack");
        @(negedge clk);
        fuse_blow_i = 1'b1;
        @(negedge clk);
        fuse_blow_i = 1'b0;
        send(2'b11, 1'b0);
        chk("R7 set-secure granted under lock", resp(), 8'b1000);
        send(2'b01, 1'b0);
        chk("R5 locked erase denied 10", resp(), 8'b0110);
        chk("R5 no memory request", {7'b0, mem_req_o}, 8'h00);
        send(2'b10, 1'b0);
        chk("R5 locked program denied 10", resp(), 8'b0110);
        send(2'b00, 1'b0);
        chk("R1 read of secured sram denied 01", resp(), 8'b0101);
        send(2'b10, 1'b1);
        chk("R5 nv program unaffected", resp(), 8'b1000);
        ack("R5 ack");
        do_reset();
        send(2'b01, 1'b0);
        chk("R6 lock survives reset", resp(), 8'b0110);
        send(2'b10, 1'b0);
        chk("R6 program still locked", resp(), 8'b0110);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_plain_read();
        t_secure_isolation();
        t_erase_then_program();
        t_nv_retention();
        t_busy_hold();
        t_lock();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule